// File: doc/BRIEF.md
# Runlist Timeslice Channel Scheduler

This block decides which channel an execution engine works on. Software loads a small runlist through a write port. Each slot holds either a group of channels that share one context or a single channel. Software raises a per-channel pending flag whenever a channel is given new work. The scheduler gives the engine to one channel at a time and reports that channel and its ID.

The running channel is replaced for one of three reasons:

- the engine reports the work as finished;
- a programmable timeslice runs out;
- an external preempt strobe arrives.

When the engine is to be replaced, the scheduler searches the runlist in a circle, starting from the slot after the one that just ran. It skips slots that are empty or that have no pending channel, and it takes the lowest-numbered pending channel of the first eligible slot. Every replacement gives a one-cycle report with the cause, the outgoing channel and the incoming channel. When nothing is pending, the block sits idle.

Top module: `rls_sched`

## Requirements
- R1: After reset, `idle` is 1, `active_vld` is 0, `active_ch` is 0 and `sw_pulse` is 0.
- R2: A slot written with `rl_grp`=1 covers channels `rl_base` to `rl_base+rl_cnt-1`. A slot written with `rl_grp`=0 covers only channel `rl_base`, and its `rl_cnt` is ignored. A slot written with `rl_valid`=0 covers no channel. Within the chosen slot, the lowest-numbered pending channel runs.
- R3: The search for the next slot starts one slot after the last slot used (slot 0 after reset). It goes upward and wraps around, and the slot just left is examined last. Slots with no pending channel are skipped.
- R4: While idle, a `notify_vld` for a covered channel makes that channel active after the same clock edge. The switch report then shows cause 0 (start), `sw_out_vld`=0 and `sw_in_ch` equal to that channel.
- R5: `eng_done` while a channel is active causes a switch at that edge with cause 1 (done), and clears the outgoing channel's pending flag.
- R6: A timeslice counter is reloaded from `ts_len` at every switch. With no other cause, a channel stays active for `ts_len`+1 cycles and is then switched out with cause 2 (expiry). Its pending flag is kept.
- R7: `preempt_req` while a channel is active causes a switch at that edge with cause 3 (preempt), and the pending flag is kept.
- R8: When causes coincide, exactly one switch report is produced. Preempt ranks above expiry, which ranks above done. The pending flag is cleared only when done is the reported cause.
- R9: When a switch finds no covered pending channel, the report shows `sw_in_vld`=0. The block then shows `idle`=1, `active_vld`=0 and `active_ch`=0.
- R10: `eng_done` and `preempt_req` while idle are ignored: no report is produced and the block stays idle.
- R11: `sw_pulse` lasts one cycle. `sw_out_ch` and `sw_out_vld` give the channel that was active before the edge. `sw_in_ch` and `sw_in_vld` equal the new `active_ch` and `active_vld`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rl_we | input | 1 | Runlist slot write strobe |
| rl_idx | input | ENT_W | Slot index to write |
| rl_valid | input | 1 | Slot is in use |
| rl_grp | input | 1 | 1: group slot, 0: single-channel slot |
| rl_base | input | CH_W | First channel covered by the slot |
| rl_cnt | input | CNT_W | Channel count of a group slot |
| ts_len | input | TS_W | Timeslice length in cycles, minus one |
| notify_vld | input | 1 | Pending-work notification strobe |
| notify_ch | input | CH_W | Channel given new work |
| eng_done | input | 1 | Engine finished the active channel's work |
| preempt_req | input | 1 | External preempt strobe |
| active_vld | output | 1 | A channel owns the engine |
| active_ch | output | CH_W | Channel owning the engine (0 when idle) |
| idle | output | 1 | No channel owns the engine |
| sw_pulse | output | 1 | One-cycle switch report |
| sw_cause | output | 2 | 0 start, 1 done, 2 expiry, 3 preempt |
| sw_out_vld | output | 1 | Outgoing channel field is meaningful |
| sw_out_ch | output | CH_W | Channel switched out |
| sw_in_vld | output | 1 | Incoming channel field is meaningful |
| sw_in_ch | output | CH_W | Channel switched in |

## Verification
Completion can arrive in the same cycle as a preempt strobe or as a timeslice expiry, and the design must rank these cases correctly. The bench forces expiry on every cycle by setting `ts_len` to 0. It then drives `eng_done` together with `preempt_req`, and then `eng_done` alone against the running expiry. Each case is judged by the reported cause and by whether the same channel is picked again; it is picked again only if its pending flag survived. The bench also sweeps every channel through two runlist layouts and predicts from the written slot fields whether each channel can run. It measures the cycles between expiry reports for several timeslice lengths.

// File: rtl/rls_pkg.sv
package rls_pkg;
  typedef enum logic [1:0] {
    CAUSE_START   = 2'd0,
    CAUSE_DONE    = 2'd1,
    CAUSE_EXPIRE  = 2'd2,
    CAUSE_PREEMPT = 2'd3
  } sw_cause_e;
endpackage

// File: rtl/rls_table.sv
// Runlist slot storage; presents the channel membership mask of each slot.
module rls_table #(
  parameter int NUM_ENT = 4,
  parameter int NUM_CH  = 8,
  localparam int ENT_W  = $clog2(NUM_ENT),
  localparam int CH_W   = $clog2(NUM_CH),
  localparam int CNT_W  = $clog2(NUM_CH + 1)
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr_en,
  input  logic [ENT_W-1:0]               wr_idx,
  input  logic                           wr_valid,
  input  logic                           wr_grp,
  input  logic [CH_W-1:0]                wr_base,
  input  logic [CNT_W-1:0]               wr_cnt,
  output logic [NUM_ENT-1:0][NUM_CH-1:0] ent_mask
);
  logic [NUM_ENT-1:0] valid_q;
  logic [NUM_ENT-1:0] grp_q;
  logic [CH_W-1:0]    base_q [NUM_ENT];
  logic [CNT_W-1:0]   cnt_q  [NUM_ENT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      grp_q   <= '0;
      for (int e = 0; e < NUM_ENT; e++) begin
        base_q[e] <= '0;
        cnt_q[e]  <= '0;
      end
    end else if (wr_en) begin
      valid_q[wr_idx] <= wr_valid;
      grp_q[wr_idx]   <= wr_grp;
      base_q[wr_idx]  <= wr_base;
      cnt_q[wr_idx]   <= wr_cnt;
    end
  end

  for (genvar e = 0; e < NUM_ENT; e++) begin : g_ent
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      assign ent_mask[e][c] = valid_q[e] &&
        (grp_q[e] ? ((c >= int'(base_q[e])) && (c < int'(base_q[e]) + int'(cnt_q[e])))
                  : (c == int'(base_q[e])));
    end
  end
endmodule

// File: rtl/rls_pending.sv
// Per-channel pending-work flags; a set in the same cycle wins over a clear.
module rls_pending #(
  parameter int NUM_CH = 8,
  localparam int CH_W  = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_en,
  input  logic [CH_W-1:0]   set_ch,
  input  logic              clr_en,
  input  logic [CH_W-1:0]   clr_ch,
  output logic [NUM_CH-1:0] pend_nx
);
  logic [NUM_CH-1:0] pend_q;
  logic [NUM_CH-1:0] set_v, clr_v;

  always_comb begin
    set_v = '0;
    clr_v = '0;
    if (set_en) set_v[set_ch] = 1'b1;
    if (clr_en) clr_v[clr_ch] = 1'b1;
    pend_nx = (pend_q & ~clr_v) | set_v;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_nx;
  end
endmodule

// File: rtl/rls_pick.sv
// Circular search for the next eligible slot and its lowest pending channel.
module rls_pick #(
  parameter int NUM_ENT = 4,
  parameter int NUM_CH  = 8,
  localparam int ENT_W  = $clog2(NUM_ENT),
  localparam int CH_W   = $clog2(NUM_CH)
) (
  input  logic [NUM_ENT-1:0][NUM_CH-1:0] ent_mask,
  input  logic [NUM_CH-1:0]              pend,
  input  logic [ENT_W-1:0]               last_idx,
  output logic                           found,
  output logic [ENT_W-1:0]               sel_idx,
  output logic [CH_W-1:0]                sel_ch
);
  logic [NUM_CH-1:0] hitv;

  always_comb begin
    found   = 1'b0;
    sel_idx = '0;
    for (int k = 1; k <= NUM_ENT; k++) begin
      int idx;
      idx = int'(last_idx) + k;
      if (idx >= NUM_ENT) idx = idx - NUM_ENT;
      if (!found && (|(ent_mask[idx] & pend))) begin
        found   = 1'b1;
        sel_idx = ENT_W'(idx);
      end
    end
    hitv   = ent_mask[sel_idx] & pend;
    sel_ch = '0;
    for (int c = NUM_CH - 1; c >= 0; c--) begin
      if (hitv[c]) sel_ch = CH_W'(c);
    end
  end
endmodule

// File: rtl/rls_slice.sv
// Timeslice down-counter; expiry when the running count reaches zero.
module rls_slice #(
  parameter int TS_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic            reload,
  input  logic [TS_W-1:0] len,
  output logic            expired
);
  logic [TS_W-1:0] ts_q, ts_d;
  logic            ts_en;

  always_comb begin
    ts_en = reload || (run && (ts_q != '0));
    ts_d  = reload ? len : ts_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ts_q <= '0;
    else if (ts_en) ts_q <= ts_d;
  end

  assign expired = run && (ts_q == '0);
endmodule

// File: rtl/rls_sched.sv
module rls_sched #(
  parameter int NUM_ENT = 4,
  parameter int NUM_CH  = 8,
  parameter int TS_W    = 8,
  localparam int ENT_W  = $clog2(NUM_ENT),
  localparam int CH_W   = $clog2(NUM_CH),
  localparam int CNT_W  = $clog2(NUM_CH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rl_we,
  input  logic [ENT_W-1:0] rl_idx,
  input  logic             rl_valid,
  input  logic             rl_grp,
  input  logic [CH_W-1:0]  rl_base,
  input  logic [CNT_W-1:0] rl_cnt,
  input  logic [TS_W-1:0]  ts_len,
  input  logic             notify_vld,
  input  logic [CH_W-1:0]  notify_ch,
  input  logic             eng_done,
  input  logic             preempt_req,
  output logic             active_vld,
  output logic [CH_W-1:0]  active_ch,
  output logic             idle,
  output logic             sw_pulse,
  output logic [1:0]       sw_cause,
  output logic             sw_out_vld,
  output logic [CH_W-1:0]  sw_out_ch,
  output logic             sw_in_vld,
  output logic [CH_W-1:0]  sw_in_ch
);
  import rls_pkg::*;

  // reset: asserted asynchronously, released on a clock edge
  logic rst_meta_q, rst_q_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_q_n    <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_q_n    <= rst_meta_q;
    end
  end

  logic                           cur_vld_q, cur_vld_d;
  logic [CH_W-1:0]                cur_ch_q, cur_ch_d;
  logic [ENT_W-1:0]               ptr_q, ptr_d;
  logic                           pulse_q;
  sw_cause_e                      cause_q, cause_d;
  logic                           out_vld_q, in_vld_q;
  logic [CH_W-1:0]                out_ch_q, in_ch_q;

  logic [NUM_ENT-1:0][NUM_CH-1:0] ent_mask;
  logic [NUM_CH-1:0]              pend_nx;
  logic                           pick_found;
  logic [ENT_W-1:0]               pick_idx;
  logic [CH_W-1:0]                pick_ch;
  logic                           ts_expired;
  logic                           hit_pre, hit_done, run_sw, start_sw, do_sw, clr_en;

  rls_table #(.NUM_ENT(NUM_ENT), .NUM_CH(NUM_CH)) u_table (
    .clk(clk), .rst_n(rst_q_n), .wr_en(rl_we), .wr_idx(rl_idx),
    .wr_valid(rl_valid), .wr_grp(rl_grp), .wr_base(rl_base), .wr_cnt(rl_cnt),
    .ent_mask(ent_mask)
  );

  rls_pending #(.NUM_CH(NUM_CH)) u_pend (
    .clk(clk), .rst_n(rst_q_n), .set_en(notify_vld), .set_ch(notify_ch),
    .clr_en(clr_en), .clr_ch(cur_ch_q), .pend_nx(pend_nx)
  );

  rls_pick #(.NUM_ENT(NUM_ENT), .NUM_CH(NUM_CH)) u_pick (
    .ent_mask(ent_mask), .pend(pend_nx), .last_idx(ptr_q),
    .found(pick_found), .sel_idx(pick_idx), .sel_ch(pick_ch)
  );

  rls_slice #(.TS_W(TS_W)) u_slice (
    .clk(clk), .rst_n(rst_q_n), .run(cur_vld_q), .reload(do_sw),
    .len(ts_len), .expired(ts_expired)
  );

  // switch decision and next state
  always_comb begin
    hit_pre  = cur_vld_q && preempt_req;
    hit_done = cur_vld_q && eng_done;
    run_sw   = hit_pre || ts_expired || hit_done;
    clr_en   = hit_done && !hit_pre && !ts_expired;
    start_sw = !cur_vld_q && pick_found;
    do_sw    = run_sw || start_sw;

    if (hit_pre)         cause_d = CAUSE_PREEMPT;
    else if (ts_expired) cause_d = CAUSE_EXPIRE;
    else if (hit_done)   cause_d = CAUSE_DONE;
    else                 cause_d = CAUSE_START;

    cur_vld_d = cur_vld_q;
    cur_ch_d  = cur_ch_q;
    ptr_d     = ptr_q;
    if (do_sw) begin
      cur_vld_d = pick_found;
      cur_ch_d  = pick_found ? pick_ch : '0;
      if (pick_found) ptr_d = pick_idx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_vld_q <= 1'b0;
      cur_ch_q  <= '0;
      ptr_q     <= ENT_W'(NUM_ENT - 1);
      pulse_q   <= 1'b0;
    end else if (!rst_q_n) begin
      cur_vld_q <= 1'b0;
      cur_ch_q  <= '0;
      ptr_q     <= ENT_W'(NUM_ENT - 1);
      pulse_q   <= 1'b0;
    end else begin
      cur_vld_q <= cur_vld_d;
      cur_ch_q  <= cur_ch_d;
      ptr_q     <= ptr_d;
      pulse_q   <= do_sw;
    end
  end

  // switch report fields, captured only on a switch
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cause_q   <= CAUSE_START;
      out_vld_q <= 1'b0;
      out_ch_q  <= '0;
      in_vld_q  <= 1'b0;
      in_ch_q   <= '0;
    end else if (rst_q_n && do_sw) begin
      cause_q   <= cause_d;
      out_vld_q <= cur_vld_q;
      out_ch_q  <= cur_ch_q;
      in_vld_q  <= pick_found;
      in_ch_q   <= pick_found ? pick_ch : '0;
    end
  end

  assign active_vld = cur_vld_q;
  assign active_ch  = cur_ch_q;
  assign idle       = !cur_vld_q;
  assign sw_pulse   = pulse_q;
  assign sw_cause   = cause_q;
  assign sw_out_vld = out_vld_q;
  assign sw_out_ch  = out_ch_q;
  assign sw_in_vld  = in_vld_q;
  assign sw_in_ch   = in_ch_q;
endmodule

// File: rtl/rls_sched_chk.sv
module rls_sched_chk #(
  parameter int CH_W = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic            eng_done,
  input logic            preempt_req,
  input logic            active_vld,
  input logic [CH_W-1:0] active_ch,
  input logic            sw_pulse,
  input logic [1:0]      sw_cause,
  input logic            sw_out_vld,
  input logic [CH_W-1:0] sw_out_ch,
  input logic            sw_in_vld,
  input logic [CH_W-1:0] sw_in_ch
);
  assert_in_matches_R11: assert property (@(posedge clk) disable iff (!rst_n)
    sw_pulse |-> (sw_in_vld == active_vld) && (sw_in_ch == active_ch));

  assert_out_matches_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_pulse && sw_out_vld) |-> ($past(active_vld) && (sw_out_ch == $past(active_ch))));

  assert_change_reported_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (active_ch != $past(active_ch)) |-> sw_pulse);

  assert_idle_no_channel_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !active_vld |-> (active_ch == '0));

  assert_start_from_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_pulse && !$past(active_vld)) |-> (!sw_out_vld && (sw_cause == 2'd0)));

  assert_done_switches_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_done && active_vld && !preempt_req) |=> sw_pulse);

  assert_preempt_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (preempt_req && active_vld) |=> (sw_pulse && (sw_cause == 2'd3)));
endmodule

bind rls_sched rls_sched_chk #(.CH_W(CH_W)) u_chk (
  .clk(clk), .rst_n(rst_q_n), .eng_done(eng_done), .preempt_req(preempt_req),
  .active_vld(active_vld), .active_ch(active_ch), .sw_pulse(sw_pulse),
  .sw_cause(sw_cause), .sw_out_vld(sw_out_vld), .sw_out_ch(sw_out_ch),
  .sw_in_vld(sw_in_vld), .sw_in_ch(sw_in_ch)
);

// File: tb/test_rls_sched.sv
module test_rls_sched;
  localparam int NE = 4;
  localparam int NC = 8;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       rl_we, rl_valid, rl_grp;
  logic [1:0] rl_idx;
  logic [2:0] rl_base;
  logic [3:0] rl_cnt;
  logic [7:0] ts_len;
  logic       notify_vld;
  logic [2:0] notify_ch;
  logic       eng_done, preempt_req;
  logic       active_vld, idle, sw_pulse, sw_out_vld, sw_in_vld;
  logic [2:0] active_ch, sw_out_ch, sw_in_ch;
  logic [1:0] sw_cause;

  int checks = 0;
  int errors = 0;
  bit m_valid [NE];
  bit m_grp   [NE];
  int m_base  [NE];
  int m_cnt   [NE];

  always #2 clk = ~clk;

  rls_sched i_rls_sched (
    .clk(clk), .rst_n(rst_n), .rl_we(rl_we), .rl_idx(rl_idx), .rl_valid(rl_valid),
    .rl_grp(rl_grp), .rl_base(rl_base), .rl_cnt(rl_cnt), .ts_len(ts_len),
    .notify_vld(notify_vld), .notify_ch(notify_ch), .eng_done(eng_done),
    .preempt_req(preempt_req), .active_vld(active_vld), .active_ch(active_ch),
    .idle(idle), .sw_pulse(sw_pulse), .sw_cause(sw_cause), .sw_out_vld(sw_out_vld),
    .sw_out_ch(sw_out_ch), .sw_in_vld(sw_in_vld), .sw_in_ch(sw_in_ch)
  );

  task automatic tick;
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp_v);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp_v);
    end
  endtask

  task automatic chk_eq(input string req, input int act, input int exp_v);
    chk(act == exp_v, req, act, exp_v);
  endtask

  task automatic wr_ent(input int idx, input bit v, input bit g, input int b, input int c);
    rl_we = 1'b1; rl_idx = 2'(idx); rl_valid = v; rl_grp = g;
    rl_base = 3'(b); rl_cnt = 4'(c);
    tick();
    rl_we = 1'b0;
    m_valid[idx] = v; m_grp[idx] = g; m_base[idx] = b; m_cnt[idx] = c;
  endtask

  task automatic notify(input int ch);
    notify_vld = 1'b1; notify_ch = 3'(ch);
    tick();
    notify_vld = 1'b0;
  endtask

  function automatic bit covered(input int ch);
    bit r = 1'b0;
    for (int e = 0; e < NE; e++) begin
      if (m_valid[e] && (m_grp[e] ? (ch >= m_base[e] && ch < m_base[e] + m_cnt[e])
                                  : (ch == m_base[e]))) r = 1'b1;
    end
    return r;
  endfunction

  task automatic chk_switch(input string req, input int cause, input int out_ch, input int in_ch);
    chk_eq({req, " pulse"}, int'(sw_pulse), 1);
    chk_eq({req, " cause"}, int'(sw_cause), cause);
    if (out_ch >= 0) chk_eq({req, " out_ch"}, int'(sw_out_ch), out_ch);
    chk_eq({req, " in_ch"}, int'(sw_in_ch), in_ch);
    chk_eq({req, " active_ch"}, int'(active_ch), in_ch);
  endtask

  task automatic wait_pulse;
    for (int i = 0; i < 1000; i++) begin
      tick();
      if (sw_pulse) break;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual 0 expected 1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; rl_we = 1'b0; rl_idx = '0; rl_valid = 1'b0; rl_grp = 1'b0;
    rl_base = '0; rl_cnt = '0; ts_len = 8'd200; notify_vld = 1'b0; notify_ch = '0;
    eng_done = 1'b0; preempt_req = 1'b0;
    for (int e = 0; e < NE; e++) begin
      m_valid[e] = 1'b0; m_grp[e] = 1'b0; m_base[e] = 0; m_cnt[e] = 0;
    end
    repeat (3) tick();
    rst_n = 1'b1;
    repeat (4) tick();

    // R1 reset state
    chk_eq("R1 idle", int'(idle), 1);
    chk_eq("R1 active_vld", int'(active_vld), 0);
    chk_eq("R1 active_ch", int'(active_ch), 0);
    chk_eq("R1 sw_pulse", int'(sw_pulse), 0);

    // slot 0: group ch0..2, slot 1: single ch3 (count ignored), slot 2: group ch4..5, slot 3 unused
    wr_ent(0, 1, 1, 0, 3);
    wr_ent(1, 1, 0, 3, 5);
    wr_ent(2, 1, 1, 4, 2);
    wr_ent(3, 0, 1, 6, 2);

    // R10 strobes while idle are ignored
    eng_done = 1'b1; preempt_req = 1'b1;
    tick();
    eng_done = 1'b0; preempt_req = 1'b0;
    chk_eq("R10 no pulse", int'(sw_pulse), 0);
    tick();
    chk_eq("R10 still idle", int'(idle), 1);

    // R4 start from idle
    notify(4);
    chk_switch("R4", 0, -1, 4);
    chk_eq("R4 out_vld", int'(sw_out_vld), 0);
    chk_eq("R4 active_vld", int'(active_vld), 1);

    notify(1); notify(0); notify(3);
    chk_eq("R11 no pulse while running", int'(sw_pulse), 0);

    // R5/R3/R2: done on ch4, search 3 (unused) then 0 -> lowest pending ch0
    eng_done = 1'b1; tick(); eng_done = 1'b0;
    chk_switch("R5 R2 R3", 1, 4, 0);
    chk_eq("R11 out_vld", int'(sw_out_vld), 1);

    // R7 preempt: search from slot 1 -> ch3
    preempt_req = 1'b1; tick(); preempt_req = 1'b0;
    chk_switch("R7", 3, 0, 3);

    // R3 skip: done ch3, slot 2 empty, slot 3 unused, slot 0 ch0 kept by preempt
    eng_done = 1'b1; tick(); eng_done = 1'b0;
    chk_switch("R3 R7 kept", 1, 3, 0);

    // R3 wrap to the same slot last: done ch0 -> ch1
    eng_done = 1'b1; tick(); eng_done = 1'b0;
    chk_switch("R3 R5 cleared", 1, 0, 1);

    // R6 timeslice lengths
    for (int len = 0; len < 6; len++) begin
      int n;
      ts_len = 8'(len);
      wait_pulse();
      n = 0;
      for (int i = 0; i < 300; i++) begin
        tick();
        n++;
        if (sw_pulse) break;
      end
      chk_eq("R6 slice cycles", n, len + 1);
      chk_switch("R6 expiry keeps ch1", 2, 1, 1);
    end

    // R8 priorities with expiry on every cycle
    ts_len = 8'd0;
    wait_pulse();
    eng_done = 1'b1; preempt_req = 1'b1; tick(); eng_done = 1'b0; preempt_req = 1'b0;
    chk_switch("R8 preempt over done", 3, 1, 1);
    chk_eq("R8 still active", int'(active_vld), 1);
    eng_done = 1'b1; tick(); eng_done = 1'b0;
    chk_switch("R8 expiry over done", 2, 1, 1);
    ts_len = 8'd200;
    tick();
    chk_switch("R6 reload", 2, 1, 1);
    eng_done = 1'b1; tick(); eng_done = 1'b0;
    chk_eq("R9 pulse", int'(sw_pulse), 1);
    chk_eq("R9 cause done", int'(sw_cause), 1);
    chk_eq("R9 in_vld", int'(sw_in_vld), 0);
    chk_eq("R9 idle", int'(idle), 1);
    chk_eq("R9 active_vld", int'(active_vld), 0);
    chk_eq("R9 active_ch", int'(active_ch), 0);

    // R2 membership sweep over two layouts
    for (int cfg = 0; cfg < 2; cfg++) begin
      if (cfg == 0) wr_ent(3, 1, 1, 6, 2);
      else          wr_ent(3, 0, 1, 6, 2);
      for (int ch = 0; ch < NC; ch++) begin
        bit exp_run;
        exp_run = covered(ch);
        notify(ch);
        chk_eq("R2 sweep runs", int'(active_vld), int'(exp_run));
        if (exp_run) begin
          chk_eq("R2 sweep channel", int'(active_ch), ch);
          eng_done = 1'b1; tick(); eng_done = 1'b0;
          chk_eq("R9 sweep back to idle", int'(idle), 1);
        end else begin
          chk_eq("R2 sweep no pulse", int'(sw_pulse), 0);
        end
      end
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule